// File: doc/BRIEF.md
# Partition ID Limit Enforcer

This block sits on an ID stream that a host has already sorted and grouped by sample. Each beat carries a row index (the sample) and a column index (the ID value). The block routes every ID to one of a fixed number of partitions by taking the column index modulo the partition count. It keeps two running tallies per partition for the current step: all accepted IDs, and accepted IDs that differ from the previous accepted ID of that partition. Because the input is sorted, comparing against the last accepted ID is enough to spot a new unique value.

Each partition has two ceilings, one on its total tally and one on its unique tally. These are loaded through a configuration port while the stream is idle. An ID that would push either tally past its ceiling counts as a violation. A policy bit decides what happens next. With dropping enabled, the ID is discarded, a one-cycle drop strobe names its partition, and the stream carries on. With dropping disabled, which is the reset default, a sticky error flag is raised, the offending partition is recorded, and input is refused. A step-start pulse clears the tallies, the uniqueness memory and the error flag, which opens a new mini-batch.

Top module: `id_limit_enforcer`

## Requirements
- R1: An accepted ID is forwarded with its row and column unchanged and with partition equal to the low log2(PART_N) bits of the column index (col mod PART_N).
- R2: Within one step, a partition forwards at most its total ceiling of IDs, duplicates included. The next ID for that partition is a violation.
- R3: An ID is unique when it differs from the last ID accepted for its partition in the current step. Once a partition's unique tally equals its unique ceiling, a new unique ID is a violation, while a repeat of the last accepted ID still passes if the total ceiling allows.
- R4: With dropping enabled (cfg_drop_en = 1), a violating ID is not forwarded. drop_valid is high for the one cycle after the ID is taken, with drop_part naming the partition. The tallies stay unchanged and input continues to be accepted.
- R5: With dropping disabled (cfg_drop_en = 0), a violating ID is not forwarded. err goes high in the cycle after the ID is taken, err_part names the partition, and err stays high with in_ready low until a step start.
- R6: A step_start pulse clears all tallies, the uniqueness memory and err. in_ready is low in the cycle in which step_start is high.
- R7: A configuration write (cfg_we) is applied only when in_valid is low and no output is pending. Otherwise it is ignored.
- R8: After reset, out_valid, drop_valid and err are low, in_ready is high, dropping is disabled, and every ceiling is at its all-ones maximum.
- R9: While out_valid is high and out_ready is low, the output payload holds steady and in_ready is low.
- R10: The tallies and ceilings of one partition do not affect the handling of IDs routed to another partition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step_start | input | 1 | Step boundary pulse; clears tallies and error |
| cfg_we | input | 1 | Configuration write strobe, honoured only when idle |
| cfg_part | input | $clog2(PART_N) | Partition whose ceilings are written |
| cfg_max_all | input | CNT_W | Total-ID ceiling for cfg_part |
| cfg_max_uniq | input | CNT_W | Unique-ID ceiling for cfg_part |
| cfg_drop_en | input | 1 | Policy: 1 drops violating IDs, 0 halts with error |
| in_valid | input | 1 | Input ID valid |
| in_ready | output | 1 | Input ID accepted when high together with in_valid |
| in_row | input | ROW_W | Sample index of the ID |
| in_col | input | COL_W | ID value |
| out_valid | output | 1 | Forwarded ID valid |
| out_ready | input | 1 | Downstream ready |
| out_row | output | ROW_W | Forwarded sample index |
| out_col | output | COL_W | Forwarded ID value |
| out_part | output | $clog2(PART_N) | Partition of forwarded ID |
| drop_valid | output | 1 | One-cycle strobe for a dropped ID |
| drop_part | output | $clog2(PART_N) | Partition of the dropped ID |
| err | output | 1 | Sticky limit-violation error |
| err_part | output | $clog2(PART_N) | Partition that caused the error |

## Verification
A tally that is off by one shows up on the first ID that reaches a ceiling. That ID is either forwarded when it should be dropped, or dropped one ID too early, and in both cases the difference appears on out_valid or drop_valid in the cycle after the ID is taken. A stale uniqueness memory makes a repeat look new, or a new value look like a repeat, so the unique ceiling trips at the wrong ID. The directed tests walk each partition's tallies up to and across its ceilings to expose this. A missed clear at step start leaves err high or causes an early drop on the first IDs of the next step.

// File: rtl/ile_pkg.sv
package ile_pkg;

    typedef enum logic [1:0] {
        VERD_PASS = 2'd0,
        VERD_DROP = 2'd1,
        VERD_HALT = 2'd2
    } verdict_e;

    function automatic verdict_e judge(input logic over, input logic drop_en);
        if (!over) begin
            return VERD_PASS;
        end
        return drop_en ? VERD_DROP : VERD_HALT;
    endfunction

endpackage

// File: rtl/ile_part_slot.sv
module ile_part_slot #(
    parameter int COL_W = 16,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             cfg_we,
    input  logic [CNT_W-1:0] cfg_max_all,
    input  logic [CNT_W-1:0] cfg_max_uniq,
    input  logic [COL_W-1:0] probe_col,
    input  logic             commit,
    output logic             over_all,
    output logic             over_uniq,
    output logic             fresh
);

    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] tot;
        logic [CNT_W-1:0] uniq;
        logic [COL_W-1:0] last;
        logic             seen;
        logic [CNT_W-1:0] lim_all;
        logic [CNT_W-1:0] lim_uniq;
    } slot_t;

    slot_t st_d, st_q;

    always_comb begin
        fresh     = !st_q.seen || (st_q.last != probe_col);
        over_all  = st_q.tot >= st_q.lim_all;
        over_uniq = fresh && (st_q.uniq >= st_q.lim_uniq);

        st_d = st_q;
        if (cfg_we) begin
            st_d.lim_all  = cfg_max_all;
            st_d.lim_uniq = cfg_max_uniq;
        end
        if (clr) begin
            st_d.tot  = '0;
            st_d.uniq = '0;
            st_d.seen = 1'b0;
        end else if (commit) begin
            if (st_q.tot != CNT_TOP) begin
                st_d.tot = st_q.tot + 1'b1;
            end
            if (fresh && (st_q.uniq != CNT_TOP)) begin
                st_d.uniq = st_q.uniq + 1'b1;
            end
            st_d.last = probe_col;
            st_d.seen = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.tot      <= '0;
            st_q.uniq     <= '0;
            st_q.last     <= '0;
            st_q.seen     <= 1'b0;
            st_q.lim_all  <= CNT_TOP;
            st_q.lim_uniq <= CNT_TOP;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/ile_out_stage.sv
module ile_out_stage #(
    parameter int ROW_W = 16,
    parameter int COL_W = 16,
    parameter int PW    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [ROW_W-1:0] ld_row,
    input  logic [COL_W-1:0] ld_col,
    input  logic [PW-1:0]    ld_part,
    input  logic             out_ready,
    output logic             out_valid,
    output logic [ROW_W-1:0] out_row,
    output logic [COL_W-1:0] out_col,
    output logic [PW-1:0]    out_part
);

    typedef struct packed {
        logic             vld;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic [PW-1:0]    part;
    } ostg_t;

    ostg_t o_d, o_q;

    always_comb begin
        o_d = o_q;
        if (load) begin
            o_d.vld  = 1'b1;
            o_d.row  = ld_row;
            o_d.col  = ld_col;
            o_d.part = ld_part;
        end else if (out_ready) begin
            o_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign out_valid = o_q.vld;
    assign out_row   = o_q.row;
    assign out_col   = o_q.col;
    assign out_part  = o_q.part;

endmodule

// File: rtl/id_limit_enforcer.sv
module id_limit_enforcer #(
    parameter int ROW_W  = 16,
    parameter int COL_W  = 16,
    parameter int CNT_W  = 16,
    parameter int PART_N = 4,
    localparam int PW    = $clog2(PART_N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_start,
    input  logic             cfg_we,
    input  logic [PW-1:0]    cfg_part,
    input  logic [CNT_W-1:0] cfg_max_all,
    input  logic [CNT_W-1:0] cfg_max_uniq,
    input  logic             cfg_drop_en,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [ROW_W-1:0] in_row,
    input  logic [COL_W-1:0] in_col,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [ROW_W-1:0] out_row,
    output logic [COL_W-1:0] out_col,
    output logic [PW-1:0]    out_part,
    output logic             drop_valid,
    output logic [PW-1:0]    drop_part,
    output logic             err,
    output logic [PW-1:0]    err_part
);

    import ile_pkg::*;

    typedef struct packed {
        logic          err;
        logic [PW-1:0] err_part;
        logic          drop_v;
        logic [PW-1:0] drop_part;
        logic          drop_en;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [PW-1:0]     tgt;
    logic              accept;
    logic              cfg_ok;
    logic              load;
    logic              over_sel;
    verdict_e          verdict;
    logic [PART_N-1:0] over_all_v;
    logic [PART_N-1:0] over_uniq_v;
    logic [PART_N-1:0] fresh_v;
    logic [PART_N-1:0] commit_v;
    logic [PART_N-1:0] cfg_we_v;

    assign tgt      = in_col[PW-1:0];
    assign in_ready = !c_q.err && !step_start && (!out_valid || out_ready);
    assign accept   = in_valid && in_ready;
    assign cfg_ok   = cfg_we && !in_valid && !out_valid;
    assign over_sel = over_all_v[tgt] || over_uniq_v[tgt];
    assign verdict  = judge(over_sel, c_q.drop_en);
    assign load     = accept && (verdict == VERD_PASS);

    for (genvar p = 0; p < PART_N; p++) begin : g_slot
        assign commit_v[p] = load && (tgt == PW'(p));
        assign cfg_we_v[p] = cfg_ok && (cfg_part == PW'(p));

        ile_part_slot #(
            .COL_W (COL_W),
            .CNT_W (CNT_W)
        ) slot_i (
            .clk          (clk),
            .rst_n        (rst_n),
            .clr          (step_start),
            .cfg_we       (cfg_we_v[p]),
            .cfg_max_all  (cfg_max_all),
            .cfg_max_uniq (cfg_max_uniq),
            .probe_col    (in_col),
            .commit       (commit_v[p]),
            .over_all     (over_all_v[p]),
            .over_uniq    (over_uniq_v[p]),
            .fresh        (fresh_v[p])
        );
    end

    ile_out_stage #(
        .ROW_W (ROW_W),
        .COL_W (COL_W),
        .PW    (PW)
    ) ostg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .ld_row    (in_row),
        .ld_col    (in_col),
        .ld_part   (tgt),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_row   (out_row),
        .out_col   (out_col),
        .out_part  (out_part)
    );

    always_comb begin
        c_d        = c_q;
        c_d.drop_v = 1'b0;
        if (step_start) begin
            c_d.err = 1'b0;
        end
        if (accept && (verdict == VERD_DROP)) begin
            c_d.drop_v    = 1'b1;
            c_d.drop_part = tgt;
        end
        if (accept && (verdict == VERD_HALT)) begin
            c_d.err      = 1'b1;
            c_d.err_part = tgt;
        end
        if (cfg_ok) begin
            c_d.drop_en = cfg_drop_en;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign drop_valid = c_q.drop_v;
    assign drop_part  = c_q.drop_part;
    assign err        = c_q.err;
    assign err_part   = c_q.err_part;

endmodule

// File: rtl/ile_checker.sv
module ile_checker #(
    parameter int ROW_W  = 16,
    parameter int COL_W  = 16,
    parameter int PART_N = 4,
    localparam int PW    = $clog2(PART_N)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             step_start,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [ROW_W-1:0] out_row,
    input logic [COL_W-1:0] out_col,
    input logic [PW-1:0]    out_part,
    input logic             drop_valid,
    input logic             err
);

    // R1: partition of forwarded beat matches its column
    a_r1_part_route: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_part == out_col[PW-1:0]));

    // R9: payload held under backpressure
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_col) && $stable(out_row)));

    a_r9_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R5: error is sticky and blocks input
    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !step_start) |=> err);

    a_r5_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !in_ready);

    // R4: a drop never coincides with the halt state
    a_r4_drop_no_err: assert property (@(posedge clk) disable iff (!rst_n)
        drop_valid |-> !err);

    // R6: step start clears error and closes input for that cycle
    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        step_start |=> !err);

    a_r6_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
        step_start |-> !in_ready);

endmodule

bind id_limit_enforcer ile_checker #(
    .ROW_W  (ROW_W),
    .COL_W  (COL_W),
    .PART_N (PART_N)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_start (step_start),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_row    (out_row),
    .out_col    (out_col),
    .out_part   (out_part),
    .drop_valid (drop_valid),
    .err        (err)
);

// File: tb/id_limit_enforcer_tb_top.sv
module id_limit_enforcer_tb_top;

    localparam int ROW_W  = 16;
    localparam int COL_W  = 16;
    localparam int CNT_W  = 16;
    localparam int PART_N = 4;
    localparam int PW     = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             step_start = 1'b0;
    logic             cfg_we = 1'b0;
    logic [PW-1:0]    cfg_part = '0;
    logic [CNT_W-1:0] cfg_max_all = '0;
    logic [CNT_W-1:0] cfg_max_uniq = '0;
    logic             cfg_drop_en = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [ROW_W-1:0] in_row = '0;
    logic [COL_W-1:0] in_col = '0;
    logic             out_valid;
    logic             out_ready = 1'b1;
    logic [ROW_W-1:0] out_row;
    logic [COL_W-1:0] out_col;
    logic [PW-1:0]    out_part;
    logic             drop_valid;
    logic [PW-1:0]    drop_part;
    logic             err;
    logic [PW-1:0]    err_part;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    id_limit_enforcer #(
        .ROW_W  (ROW_W),
        .COL_W  (COL_W),
        .CNT_W  (CNT_W),
        .PART_N (PART_N)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .step_start   (step_start),
        .cfg_we       (cfg_we),
        .cfg_part     (cfg_part),
        .cfg_max_all  (cfg_max_all),
        .cfg_max_uniq (cfg_max_uniq),
        .cfg_drop_en  (cfg_drop_en),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .in_row       (in_row),
        .in_col       (in_col),
        .out_valid    (out_valid),
        .out_ready    (out_ready),
        .out_row      (out_row),
        .out_col      (out_col),
        .out_part     (out_part),
        .drop_valid   (drop_valid),
        .drop_part    (drop_part),
        .err          (err),
        .err_part     (err_part)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one ID; return what the ports show in the cycle after it is taken.
    task automatic send(input logic [ROW_W-1:0] row, input logic [COL_W-1:0] col,
                        output logic ov, output logic [PW-1:0] op,
                        output logic [COL_W-1:0] oc, output logic dv,
                        output logic [PW-1:0] dp, output logic ev);
        @(negedge clk);
        in_row   = row;
        in_col   = col;
        in_valid = 1'b1;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        ov = out_valid;
        op = out_part;
        oc = out_col;
        dv = drop_valid;
        dp = drop_part;
        ev = err;
    endtask

    task automatic cfg(input logic [PW-1:0] p, input logic [CNT_W-1:0] ma,
                       input logic [CNT_W-1:0] mu, input logic de);
        @(negedge clk);
        @(negedge clk);
        cfg_part     = p;
        cfg_max_all  = ma;
        cfg_max_uniq = mu;
        cfg_drop_en  = de;
        cfg_we       = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic step();
        @(negedge clk);
        step_start = 1'b1;
        @(negedge clk);
        step_start = 1'b0;
    endtask

    task automatic t_reset();
        logic ov, dv, ev;
        logic [PW-1:0] op, dp;
        logic [COL_W-1:0] oc;
        @(negedge clk);
        chk("R8 out_valid", out_valid, 0);
        chk("R8 drop_valid", drop_valid, 0);
        chk("R8 err", err, 0);
        chk("R8 in_ready", in_ready, 1);
        for (int i = 0; i < 5; i++) begin
            send(16'(i), 16'h0008, ov, op, oc, dv, dp, ev);
            chk("R8 default limits pass", ov, 1);
        end
        step();
    endtask

    task automatic t_route();
        logic ov, dv, ev;
        logic [PW-1:0] op, dp;
        logic [COL_W-1:0] oc;
        logic [COL_W-1:0] cols [3] = '{16'h0012, 16'h0025, 16'h0033};
        for (int i = 0; i < 3; i++) begin
            send(16'(i + 1), cols[i], ov, op, oc, dv, dp, ev);
            chk("R1 valid", ov, 1);
            chk("R1 part", op, 32'(cols[i] % PART_N));
            chk("R1 col", oc, cols[i]);
            chk("R1 row", out_row, 32'(i + 1));
        end
        step();
    endtask

    task automatic t_total();
        logic ov, dv, ev;
        logic [PW-1:0] op, dp;
        logic [COL_W-1:0] oc;
        cfg(2'd1, 16'd3, 16'hFFFF, 1'b1);
        step();
        send(0, 16'h0001, ov, op, oc, dv, dp, ev); chk("R2 first", ov, 1);
        send(0, 16'h0005, ov, op, oc, dv, dp, ev); chk("R2 second", ov, 1);
        send(1, 16'h0009, ov, op, oc, dv, dp, ev); chk("R2 third", ov, 1);
        send(1, 16'h000D, ov, op, oc, dv, dp, ev);
        chk("R2 fourth blocked", ov, 0);
        chk("R4 drop strobe", dv, 1);
        chk("R4 drop part", dp, 1);
        chk("R4 no err", ev, 0);
        @(negedge clk);
        chk("R4 strobe one cycle", drop_valid, 0);
        chk("R4 ready after drop", in_ready, 1);
        send(2, 16'h0002, ov, op, oc, dv, dp, ev);
        chk("R10 other partition passes", ov, 1);
        send(2, 16'h0011, ov, op, oc, dv, dp, ev);
        chk("R4 tally unchanged by drop", dv, 1);
        step();
        send(3, 16'h0001, ov, op, oc, dv, dp, ev);
        chk("R6 tally cleared", ov, 1);
        step();
    endtask

    task automatic t_unique();
        logic ov, dv, ev;
        logic [PW-1:0] op, dp;
        logic [COL_W-1:0] oc;
        cfg(2'd0, 16'hFFFF, 16'd2, 1'b1);
        step();
        send(0, 16'h0004, ov, op, oc, dv, dp, ev); chk("R3 u1", ov, 1);
        send(0, 16'h0004, ov, op, oc, dv, dp, ev); chk("R3 repeat", ov, 1);
        send(1, 16'h0008, ov, op, oc, dv, dp, ev); chk("R3 u2", ov, 1);
        send(1, 16'h0008, ov, op, oc, dv, dp, ev); chk("R3 repeat2", ov, 1);
        send(2, 16'h000C, ov, op, oc, dv, dp, ev);
        chk("R3 third unique blocked", ov, 0);
        chk("R3 third unique dropped", dv, 1);
        send(2, 16'h0008, ov, op, oc, dv, dp, ev);
        chk("R3 repeat after drop passes", ov, 1);
        step();
        send(3, 16'h000C, ov, op, oc, dv, dp, ev);
        chk("R6 unique memory cleared", ov, 1);
        step();
    endtask

    task automatic t_error();
        logic ov, dv, ev;
        logic [PW-1:0] op, dp;
        logic [COL_W-1:0] oc;
        cfg(2'd3, 16'd1, 16'hFFFF, 1'b0);
        step();
        send(0, 16'h0003, ov, op, oc, dv, dp, ev); chk("R5 first passes", ov, 1);
        send(0, 16'h0007, ov, op, oc, dv, dp, ev);
        chk("R5 blocked", ov, 0);
        chk("R5 err", ev, 1);
        chk("R5 no drop", dv, 0);
        chk("R5 err_part", err_part, 3);
        repeat (3) @(negedge clk);
        chk("R5 still err", err, 1);
        chk("R5 ready low", in_ready, 0);
        @(negedge clk);
        step_start = 1'b1;
        #1;
        chk("R6 ready low during step", in_ready, 0);
        @(negedge clk);
        step_start = 1'b0;
        #1;
        chk("R6 err cleared", err, 0);
        chk("R6 ready back", in_ready, 1);
    endtask

    task automatic t_cfg_busy();
        logic ov, dv, ev;
        logic [PW-1:0] op, dp;
        logic [COL_W-1:0] oc;
        out_ready = 1'b0;
        send(7, 16'h0016, ov, op, oc, dv, dp, ev);
        chk("R9 valid held", ov, 1);
        cfg_part = 2'd2; cfg_max_all = 16'd0; cfg_max_uniq = 16'd0; cfg_drop_en = 1'b1;
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        repeat (2) @(negedge clk);
        chk("R9 still valid", out_valid, 1);
        chk("R9 col stable", out_col, 16'h0016);
        chk("R9 ready low", in_ready, 0);
        out_ready = 1'b1;
        @(negedge clk);
        chk("R9 consumed", out_valid, 0);
        step();
        send(8, 16'h0006, ov, op, oc, dv, dp, ev);
        chk("R7 busy cfg ignored", ov, 1);
        send(8, 16'h000A, ov, op, oc, dv, dp, ev);
        chk("R7 busy cfg ignored drop off", dv, 0);
        step();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_route();
        t_total();
        t_unique();
        t_error();
        t_cfg_busy();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule